// File: doc/BRIEF.md
# Hit-Gated Frame Delay Ring

This block keeps the most recent camera frames in a circular on-chip store, so that image data can be taken out up to fifteen frames after capture. Pixels arrive as a stream with a valid strobe and an end-of-frame marker. While a frame is written, the block counts the non-zero pixels in it. On the last pixel it compares that count with a threshold and tags the frame as kept or dropped.

A reader names a frame by its age and a pixel by its address inside the frame. Age 1 is the most recently completed frame. The reader can fetch pixels from kept frames in any order. A fetch from a dropped frame, a frame that was never written, or a frame that has been overwritten returns an error strobe instead of data. Read results pass through a one-entry holding register, which places the answer one cycle after the request. A completion strobe reports the count and the decision for each frame, so downstream logic learns which frames it may read.

Top module: `frame_ring_gate`

## Requirements
- R1: After reset `rdValid` and `doneStb` are low and every slot is empty: a read of any age returns `rdErr` high.
- R2: A read request in one cycle gives `rdValid` high in the next cycle. For a kept frame, `rdData` then equals the pixel that was written at `rdAddr` of the frame `rdAge` frames back, where age 1 is the latest completed frame.
- R3: Reads may use any ages and addresses in any order. Each returned pixel depends only on that request's age and address.
- R4: The cycle after the pixel beat that carries `pixLast`, `doneStb` pulses for one cycle. `doneCount` then equals the number of non-zero pixels in that frame, including the last pixel.
- R5: The hit count saturates at 2^CNT_W-1 and does not wrap.
- R6: A frame is kept when its count is greater than or equal to `threshold`, and `doneAccept` reports this. A read of a dropped frame returns `rdErr` high.
- R7: Ages from 1 to SLOTS-1 reach stored frames. Age 0, and any age above SLOTS-1, return `rdErr`. This covers frames that the ring has overwritten.
- R8: The slot that is being refilled loses its kept tag when the pointer moves onto it, so a read that reaches a slot no completed frame has filled yet returns `rdErr`.
- R9: Whenever `rdErr` is high, `rdData` is zero.
- R10: Only the `threshold` value present on the last pixel beat decides the frame. Values driven earlier in the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel beat strobe |
| pixData | input | PIX_W | Filtered pixel value; non-zero counts as a hit |
| pixLast | input | 1 | Marks the last pixel of a frame |
| threshold | input | CNT_W | Minimum hit count for a frame to be kept |
| rdReq | input | 1 | Read request |
| rdAge | input | SLOT_W+1 | Frame age, 1 = newest completed |
| rdAddr | input | ADDR_W | Pixel address inside the frame |
| rdValid | output | 1 | Read response strobe |
| rdData | output | PIX_W | Returned pixel, zero on error |
| rdErr | output | 1 | Frame dropped, empty, or out of range |
| doneStb | output | 1 | Frame completion pulse |
| doneCount | output | CNT_W | Hit count of the completed frame |
| doneAccept | output | 1 | Keep decision of the completed frame |

## Verification
The bench uses the default parameters: 4x4-pixel frames, sixteen slots and a 4-bit hit counter. With sixteen pixels per frame, a frame with no zero pixels drives the counter past its 15 ceiling, so saturation is tested. Seventeen frames are written in total, which is enough to wrap the ring. The test can then reach the age limit of fifteen and read slots whose old contents have been replaced. Threshold values differ from frame to frame and change in the middle of a frame, so kept and dropped frames are interleaved.

// File: rtl/frame_ring_gate_pkg.sv
package frame_ring_gate_pkg;
  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic wrEn;   // store the current pixel
    logic rdEn;   // a read is requested this cycle
    logic rdErr;  // the requested frame may not be read
  } ringStrobe_t;
endpackage

// File: rtl/frame_ring_gate_ctrl.sv
module frame_ring_gate_ctrl
  import frame_ring_gate_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int SLOTS  = 16,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 4,
  parameter int SLOT_W = 4,
  parameter int AGE_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixData,
  input  logic              pixLast,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              rdReq,
  input  logic [AGE_W-1:0]  rdAge,
  output ringStrobe_t       strobe,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [SLOT_W-1:0] rdSlot,
  output logic              doneStb,
  output logic [CNT_W-1:0]  doneCount,
  output logic              doneAccept
);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [AGE_W-1:0]  AGE_MAX   = AGE_W'(SLOTS - 1);

  logic [CNT_W-1:0]  hitCnt, nextCnt;
  logic [SLOTS-1:0]  slotFull, slotKeep;
  logic [SLOT_W-1:0] nextSlot;
  logic              frameEnd, keepNow, ageOk;
  logic [AGE_W:0]    slotSum;

  always_comb begin
    nextCnt = hitCnt;
    if (pixData != '0 && hitCnt != CNT_MAX) nextCnt = hitCnt + 1'b1;
  end

  assign frameEnd = pixValid && pixLast;
  assign keepNow  = nextCnt >= threshold;
  assign nextSlot = (wrSlot == SLOT_LAST) ? '0 : wrSlot + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSlot   <= '0;
      wrAddr   <= '0;
      hitCnt   <= '0;
      slotFull <= '0;
      slotKeep <= '0;
    end else if (pixValid) begin
      if (pixLast) begin
        wrAddr             <= '0;
        hitCnt             <= '0;
        wrSlot             <= nextSlot;
        slotFull[wrSlot]   <= 1'b1;
        slotKeep[wrSlot]   <= keepNow;
        slotFull[nextSlot] <= 1'b0;
        slotKeep[nextSlot] <= 1'b0;
      end else begin
        wrAddr <= wrAddr + 1'b1;
        hitCnt <= nextCnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStb    <= 1'b0;
      doneCount  <= '0;
      doneAccept <= 1'b0;
    end else begin
      doneStb <= frameEnd;
      if (frameEnd) begin
        doneCount  <= nextCnt;
        doneAccept <= keepNow;
      end
    end
  end

  // age to slot: step back from the slot now being filled
  always_comb begin
    ageOk   = (rdAge != '0) && (rdAge <= AGE_MAX);
    slotSum = {1'b0, wrSlot} + (AGE_W+1)'(SLOTS) - {1'b0, rdAge};
    if (slotSum >= (AGE_W+1)'(SLOTS)) slotSum = slotSum - (AGE_W+1)'(SLOTS);
    rdSlot = slotSum[SLOT_W-1:0];
  end

  always_comb begin
    strobe.wrEn  = pixValid;
    strobe.rdEn  = rdReq;
    strobe.rdErr = !ageOk || !slotFull[rdSlot] || !slotKeep[rdSlot];
  end
endmodule

// File: rtl/frame_ring_gate_dp.sv
module frame_ring_gate_dp
  import frame_ring_gate_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int SLOTS     = 16,
  parameter int ADDR_W    = 4,
  parameter int SLOT_W    = 4,
  parameter int FRAME_PIX = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic [PIX_W-1:0]  pixData,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [PIX_W-1:0]  rdData,
  output logic              rdErr
);
  localparam int IDX_W = SLOT_W + ADDR_W;
  localparam int WORDS = SLOTS * FRAME_PIX;

  logic [PIX_W-1:0] store [WORDS];
  logic [IDX_W-1:0] wrIdx, rdIdx;

  assign wrIdx = {wrSlot, wrAddr};
  assign rdIdx = {rdSlot, rdAddr};

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrIdx] <= pixData;
  end

  // one-entry holding register between the store and the reader
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdErr   <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      rdErr   <= strobe.rdEn && strobe.rdErr;
      rdData  <= (strobe.rdEn && !strobe.rdErr) ? store[rdIdx] : '0;
    end
  end
endmodule

// File: rtl/frame_ring_gate.sv
module frame_ring_gate
  import frame_ring_gate_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int LOG2_COLS = 2,
  parameter int LOG2_ROWS = 2,
  parameter int SLOTS     = 16,
  parameter int CNT_W     = 4,
  parameter int ADDR_W    = LOG2_COLS + LOG2_ROWS,
  parameter int SLOT_W    = $clog2(SLOTS),
  parameter int AGE_W     = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixData,
  input  logic              pixLast,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              rdReq,
  input  logic [AGE_W-1:0]  rdAge,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [PIX_W-1:0]  rdData,
  output logic              rdErr,
  output logic              doneStb,
  output logic [CNT_W-1:0]  doneCount,
  output logic              doneAccept
);
  localparam int FRAME_PIX = 1 << ADDR_W;

  ringStrobe_t       strobe;
  logic [SLOT_W-1:0] wrSlot, rdSlot;
  logic [ADDR_W-1:0] wrAddr;

  frame_ring_gate_ctrl #(
    .PIX_W(PIX_W), .SLOTS(SLOTS), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .AGE_W(AGE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .pixLast(pixLast), .threshold(threshold), .rdReq(rdReq), .rdAge(rdAge),
    .strobe(strobe), .wrSlot(wrSlot), .wrAddr(wrAddr), .rdSlot(rdSlot),
    .doneStb(doneStb), .doneCount(doneCount), .doneAccept(doneAccept)
  );

  frame_ring_gate_dp #(
    .PIX_W(PIX_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W),
    .SLOT_W(SLOT_W), .FRAME_PIX(FRAME_PIX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixData(pixData),
    .wrSlot(wrSlot), .wrAddr(wrAddr), .rdSlot(rdSlot), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr)
  );
endmodule

// File: rtl/frame_ring_gate_chk.sv
module frame_ring_gate_chk #(
  parameter int PIX_W = 8,
  parameter int SLOTS = 16,
  parameter int CNT_W = 4,
  parameter int AGE_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             pixValid,
  input logic             pixLast,
  input logic [CNT_W-1:0] threshold,
  input logic             rdReq,
  input logic [AGE_W-1:0] rdAge,
  input logic             rdValid,
  input logic [PIX_W-1:0] rdData,
  input logic             rdErr,
  input logic             doneStb,
  input logic [CNT_W-1:0] doneCount,
  input logic             doneAccept
);
  // R2
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);
  // R2
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);
  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (rdData == '0) && rdValid);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixLast) |=> doneStb);
  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pixValid && pixLast) |=> !doneStb);
  // R10
  keep_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (doneAccept == (doneCount >= $past(threshold))));
  // R7
  age_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAge == '0) |=> rdErr);
  // R7
  age_far_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAge > AGE_W'(SLOTS - 1)) |=> rdErr);
endmodule

bind frame_ring_gate frame_ring_gate_chk #(
  .PIX_W(PIX_W), .SLOTS(SLOTS), .CNT_W(CNT_W), .AGE_W(AGE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixLast(pixLast),
  .threshold(threshold), .rdReq(rdReq), .rdAge(rdAge), .rdValid(rdValid),
  .rdData(rdData), .rdErr(rdErr), .doneStb(doneStb), .doneCount(doneCount),
  .doneAccept(doneAccept)
);

// File: tb/sim_frame_ring_gate.sv
`timescale 1ns/1ps
module sim_frame_ring_gate;
  localparam int PIX_W = 8, SLOTS = 16, CNT_W = 4, ADDR_W = 4, AGE_W = 5;
  localparam int FPIX = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic pixValid = 1'b0, pixLast = 1'b0, rdReq = 1'b0;
  logic [PIX_W-1:0]  pixData = '0;
  logic [CNT_W-1:0]  threshold = '0;
  logic [AGE_W-1:0]  rdAge = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic              rdValid, rdErr, doneStb, doneAccept;
  logic [PIX_W-1:0]  rdData;
  logic [CNT_W-1:0]  doneCount;

  int checks = 0, errors = 0, written = 0;

  always #10 clk = ~clk;

  frame_ring_gate u0 (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .pixLast(pixLast), .threshold(threshold), .rdReq(rdReq), .rdAge(rdAge),
    .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr),
    .doneStb(doneStb), .doneCount(doneCount), .doneAccept(doneAccept)
  );

  // frame model: pixels below nz(f) are hits, the rest are zero
  function automatic int nz(int f);
    return (f * 5) % 17;
  endfunction
  function automatic int hits(int f);
    return (nz(f) > 15) ? 15 : nz(f);
  endfunction
  function automatic int thr(int f);
    return (f % 2 == 1) ? 4 : 9;
  endfunction
  function automatic logic kept(int f);
    return hits(f) >= thr(f);
  endfunction
  function automatic logic [7:0] pixVal(int f, int p);
    logic [3:0] pb = 4'(p);
    logic [2:0] fb = 3'(f);
    return (p < nz(f)) ? {1'b1, pb, fb} : 8'h00;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushFrame(int f);
    for (int p = 0; p < FPIX; p++) begin
      @(negedge clk);
      pixValid  = 1'b1;
      pixData   = pixVal(f, p);
      pixLast   = (p == FPIX - 1);
      // R10: a decoy threshold is driven on every beat but the last
      threshold = (p == FPIX - 1) ? CNT_W'(thr(f)) : 4'hF;
      if (p == 3) threshold = 4'h0;
    end
    @(negedge clk);
    pixValid = 1'b0; pixLast = 1'b0; pixData = '0; threshold = '0;
    written++;
    check(doneStb === 1'b1, "R4 doneStb", int'(doneStb), 1);
    check(doneCount === CNT_W'(hits(f)), (nz(f) > 15) ? "R5 saturation" : "R4 count",
          int'(doneCount), hits(f));
    check(doneAccept === kept(f), "R6/R10 accept", int'(doneAccept), int'(kept(f)));
    @(negedge clk);
    check(doneStb === 1'b0, "R4 single pulse", int'(doneStb), 0);
  endtask

  task automatic readAt(int age, int addr, string req);
    int fr = written + 1 - age;
    logic expErr = (age == 0) || (age > SLOTS - 1) || (fr < 1) || !kept(fr);
    logic [7:0] expData = expErr ? 8'h00 : pixVal(fr, addr);
    @(negedge clk);
    rdReq = 1'b1; rdAge = AGE_W'(age); rdAddr = ADDR_W'(addr);
    @(negedge clk);
    rdReq = 1'b0;
    check(rdValid === 1'b1, {req, " valid"}, int'(rdValid), 1);
    check(rdErr === expErr, {req, " err"}, int'(rdErr), int'(expErr));
    check(rdData === expData, {req, " data (R9)"}, int'(rdData), int'(expData));
  endtask

  // read vectors after the ring has wrapped: {age, addr}
  localparam int NV = 14;
  localparam int VEC [NV][2] = '{
    '{1, 0}, '{2, 5}, '{3, 15}, '{5, 3}, '{7, 0}, '{8, 9}, '{9, 1},
    '{15, 7}, '{14, 2}, '{16, 0}, '{0, 4}, '{20, 3}, '{4, 14}, '{6, 0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rdValid === 1'b0, "R1 rdValid", int'(rdValid), 0);
    check(doneStb === 1'b0, "R1 doneStb", int'(doneStb), 0);
    readAt(1, 0, "R1 empty ring");
    for (int f = 1; f <= 3; f++) pushFrame(f);
    readAt(3, 2, "R2 oldest early frame");
    readAt(4, 0, "R8 unfilled slot");
    readAt(1, 14, "R2 newest frame");
    for (int f = 4; f <= 17; f++) pushFrame(f);
    // R3 R7 random ages and addresses after wrap
    for (int v = 0; v < NV; v++)
      readAt(VEC[v][0], VEC[v][1], (VEC[v][0] == 0 || VEC[v][0] > 15) ? "R7 range" : "R3 random");
    // R6: frame 17 has no hits and is dropped
    readAt(1, 0, "R6 dropped frame");
    // R7: deepest reachable frame, age 15
    readAt(15, 0, "R7 depth limit");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule